// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block turns indirect memory references into 32-bit data addresses. It keeps a bank of eight index pointers, each with a modifier, a buffer length and a buffer base. For each accepted access request it returns the address to use and the pointer value that results. The access names an index, a modifier (a register or a signed immediate) and a mode. Post-modify emits the pointer and then advances it. Pre-modify emits pointer plus modifier and leaves the pointer alone. Bit-reverse emits the pointer with its low bits mirrored over a programmable width and then advances it linearly.

When the global circular enable is set and the selected length is nonzero, a post-modify update folds back into the window [base, base + length). That window may start at any address. Each fold raises a one-cycle wrap pulse, which can serve as an overflow interrupt source. A second copy of the whole register bank can be selected with one control bit for a fast context switch.

Access requests enter through a valid/ready pair, and results leave through a valid/ready pair. A result is held with its data frozen while the consumer holds `out_ready` low. A new request is accepted only when the output stage is empty or is being drained in the same cycle. The register port, the control inputs and the wrap pulse are plain signals.

Top module: `circ_dag`

## Requirements
- R1: After reset, `out_valid` and `wrap_pulse` are 0, every register in both banks reads 0, circular addressing is disabled, the primary bank is selected and the bit-reverse width is 0.
- R2: When `rg_we` is high, the register selected by `rg_kind` and `rg_idx` in the active bank takes `rg_wdata` at the clock edge. The `rg_kind` encoding is 0 pointer, 1 modifier, 2 length, 3 base. `rg_rdata` shows the selected register of the active bank combinationally.
- R3: Post-modify (`acc_mode` 0) returns the old pointer as `out_addr`. The pointer becomes pointer + modifier modulo 2^32, and `out_ptr` carries that new value.
- R4: Pre-modify (`acc_mode` 1) returns pointer + modifier as `out_addr`. The pointer is left unchanged, and `out_ptr` equals the unchanged pointer.
- R5: With `acc_use_imm` high the modifier is `acc_imm`; otherwise it is modifier register `acc_mod_idx`. Either value is two's-complement signed.
- R6: In post-modify with circular enable set and a nonzero length L, a sum at or above base + L is reduced by L, and a sum below base is increased by L.
- R7: With circular enable clear or L equal to 0, post-modify updates are linear and never wrap.
- R8: Bit-reverse (`acc_mode` 2) returns the pointer with bits [W-1:0] mirrored, where W is the programmed width clamped to 32. Higher bits pass unchanged. The pointer then advances by the modifier with no wrap.
- R9: `ctl_alt_sel` written as 1 makes the alternate bank active for reads, writes and accesses. The contents of the other bank are kept.
- R10: `wrap_pulse` is high for exactly the cycle after an accepted access whose update wrapped, and low otherwise.
- R11: If a pointer write and an access that updates the same pointer happen in the same cycle, the access uses the old pointer for its address and the written value is kept.
- R12: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_ptr` stay stable and `acc_ready` is low. A request is accepted when `acc_valid` and `acc_ready` are both high. Access mode 3 behaves as post-modify.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Load the three control fields below |
| ctl_circ_en | input | 1 | Global circular addressing enable |
| ctl_alt_sel | input | 1 | Select the alternate register bank |
| ctl_brev_w | input | 6 | Bit-reverse field width |
| rg_we | input | 1 | Register write strobe |
| rg_kind | input | 2 | Register kind: 0 pointer, 1 modifier, 2 length, 3 base |
| rg_idx | input | 3 | Register index |
| rg_wdata | input | 32 | Register write data |
| rg_rdata | output | 32 | Selected register of the active bank |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted when high with valid |
| acc_idx | input | 3 | Pointer index of the access |
| acc_mode | input | 2 | 0 post, 1 pre, 2 bit-reverse, 3 post |
| acc_use_imm | input | 1 | Use the immediate as the modifier |
| acc_mod_idx | input | 3 | Modifier register index |
| acc_imm | input | 32 | Signed immediate modifier |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer ready for the result |
| out_addr | output | 32 | Generated address |
| out_ptr | output | 32 | Pointer value after the access |
| wrap_pulse | output | 1 | One-cycle circular wrap event |

## Verification
An access accepted at a rising edge has its `out_addr`, `out_ptr`, `out_valid` and `wrap_pulse` due right after that same edge. The updated pointer is visible on `rg_rdata` from that edge as well. Register writes and control loads also take effect at the edge where they are driven. `rg_rdata` follows its select inputs with no clock. The bench drives every input on the falling edge and samples results on the next falling edge, one rising edge later. In the back-pressure case it samples at each falling edge of the stall.

// File: rtl/circ_dag_pkg.sv
package circ_dag_pkg;
  typedef enum logic [1:0] {
    AM_POST = 2'd0,
    AM_PRE  = 2'd1,
    AM_BREV = 2'd2,
    AM_ALT  = 2'd3
  } am_t;

  typedef enum logic [1:0] {
    RK_PTR  = 2'd0,
    RK_MOD  = 2'd1,
    RK_LEN  = 2'd2,
    RK_BASE = 2'd3
  } rk_t;
endpackage

// File: rtl/dag_regbank.sv
module dag_regbank
  import circ_dag_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NIDX  = 8,
  parameter int NBANK = 2,
  localparam int IW   = $clog2(NIDX),
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] bank,
  input  logic          wr_en,
  input  logic [1:0]    wr_kind,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] rd_data,
  input  logic          upd_en,
  input  logic [IW-1:0] upd_idx,
  input  logic [AW-1:0] upd_val,
  input  logic [IW-1:0] sel_idx,
  input  logic [IW-1:0] sel_mod_idx,
  output logic [AW-1:0] sel_ptr,
  output logic [AW-1:0] sel_len,
  output logic [AW-1:0] sel_base,
  output logic [AW-1:0] sel_mod
);
  logic [AW-1:0] bk_rd   [NBANK];
  logic [AW-1:0] bk_ptr  [NBANK];
  logic [AW-1:0] bk_len  [NBANK];
  logic [AW-1:0] bk_base [NBANK];
  logic [AW-1:0] bk_mod  [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [AW-1:0] p_q [NIDX];
    logic [AW-1:0] m_q [NIDX];
    logic [AW-1:0] l_q [NIDX];
    logic [AW-1:0] s_q [NIDX];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NIDX; i++) begin
          p_q[i] <= '0;
          m_q[i] <= '0;
          l_q[i] <= '0;
          s_q[i] <= '0;
        end
      end else if (bank == BW'(b)) begin
        // access update first, so an explicit write in the same cycle wins
        if (upd_en) p_q[upd_idx] <= upd_val;
        if (wr_en) begin
          case (rk_t'(wr_kind))
            RK_PTR:  p_q[wr_idx] <= wr_data;
            RK_MOD:  m_q[wr_idx] <= wr_data;
            RK_LEN:  l_q[wr_idx] <= wr_data;
            default: s_q[wr_idx] <= wr_data;
          endcase
        end
      end
    end

    assign bk_rd[b]   = (wr_kind == RK_PTR) ? p_q[wr_idx] :
                        (wr_kind == RK_MOD) ? m_q[wr_idx] :
                        (wr_kind == RK_LEN) ? l_q[wr_idx] : s_q[wr_idx];
    assign bk_ptr[b]  = p_q[sel_idx];
    assign bk_len[b]  = l_q[sel_idx];
    assign bk_base[b] = s_q[sel_idx];
    assign bk_mod[b]  = m_q[sel_mod_idx];
  end

  assign rd_data  = bk_rd[bank];
  assign sel_ptr  = bk_ptr[bank];
  assign sel_len  = bk_len[bank];
  assign sel_base = bk_base[bank];
  assign sel_mod  = bk_mod[bank];
endmodule

// File: rtl/dag_addr_calc.sv
module dag_addr_calc
  import circ_dag_pkg::*;
#(
  parameter int AW  = 32,
  localparam int WW = $clog2(AW) + 1,
  localparam int XW = AW + 2
) (
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] mod,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] base,
  input  logic          circ_en,
  input  logic [1:0]    mode,
  input  logic [WW-1:0] brev_w,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] new_ptr,
  output logic          upd,
  output logic          wrapped
);
  logic signed [XW-1:0] sum_x, base_x, len_x, end_x, dn_x, up_x;
  logic [AW-1:0] rev;
  logic          circ;
  int            w_eff;

  assign sum_x  = $signed({2'b00, ptr}) + $signed({{2{mod[AW-1]}}, mod});
  assign base_x = $signed({2'b00, base});
  assign len_x  = $signed({2'b00, len});
  assign end_x  = base_x + len_x;
  assign dn_x   = sum_x - len_x;
  assign up_x   = sum_x + len_x;
  assign circ   = circ_en && (len != '0);
  assign w_eff  = (int'(brev_w) > AW) ? AW : int'(brev_w);

  always_comb begin
    rev = ptr;
    for (int k = 0; k < AW; k++) begin
      if (k < w_eff) rev[k] = ptr[w_eff - 1 - k];
    end
  end

  always_comb begin
    addr    = ptr;
    new_ptr = sum_x[AW-1:0];
    upd     = 1'b1;
    wrapped = 1'b0;
    case (am_t'(mode))
      AM_PRE: begin
        addr    = sum_x[AW-1:0];
        new_ptr = ptr;
        upd     = 1'b0;
      end
      AM_BREV: addr = rev;
      default: begin
        if (circ && (sum_x >= end_x)) begin
          new_ptr = dn_x[AW-1:0];
          wrapped = 1'b1;
        end else if (circ && (sum_x < base_x)) begin
          new_ptr = up_x[AW-1:0];
          wrapped = 1'b1;
        end
      end
    endcase
  end
endmodule

// File: rtl/circ_dag.sv
module circ_dag
  import circ_dag_pkg::*;
#(
  parameter int AW   = 32,
  parameter int NIDX = 8,
  localparam int IW  = $clog2(NIDX),
  localparam int WW  = $clog2(AW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic          ctl_circ_en,
  input  logic          ctl_alt_sel,
  input  logic [WW-1:0] ctl_brev_w,
  input  logic          rg_we,
  input  logic [1:0]    rg_kind,
  input  logic [IW-1:0] rg_idx,
  input  logic [AW-1:0] rg_wdata,
  output logic [AW-1:0] rg_rdata,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic [IW-1:0] acc_idx,
  input  logic [1:0]    acc_mode,
  input  logic          acc_use_imm,
  input  logic [IW-1:0] acc_mod_idx,
  input  logic [AW-1:0] acc_imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [AW-1:0] out_ptr,
  output logic          wrap_pulse
);
  logic          circ_en_q, alt_q;
  logic [WW-1:0] brevw_q;
  logic [AW-1:0] cur_ptr, cur_len, cur_base, cur_mod, mod_sel;
  logic [AW-1:0] c_addr, c_ptr;
  logic          c_upd, c_wrap, acc_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      circ_en_q <= 1'b0;
      alt_q     <= 1'b0;
      brevw_q   <= '0;
    end else if (ctl_we) begin
      circ_en_q <= ctl_circ_en;
      alt_q     <= ctl_alt_sel;
      brevw_q   <= ctl_brev_w;
    end
  end

  assign acc_ready = !out_valid || out_ready;
  assign acc_fire  = acc_valid && acc_ready;
  assign mod_sel   = acc_use_imm ? acc_imm : cur_mod;

  dag_regbank #(.AW(AW), .NIDX(NIDX), .NBANK(2)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank       (alt_q),
    .wr_en      (rg_we),
    .wr_kind    (rg_kind),
    .wr_idx     (rg_idx),
    .wr_data    (rg_wdata),
    .rd_data    (rg_rdata),
    .upd_en     (acc_fire && c_upd),
    .upd_idx    (acc_idx),
    .upd_val    (c_ptr),
    .sel_idx    (acc_idx),
    .sel_mod_idx(acc_mod_idx),
    .sel_ptr    (cur_ptr),
    .sel_len    (cur_len),
    .sel_base   (cur_base),
    .sel_mod    (cur_mod)
  );

  dag_addr_calc #(.AW(AW)) u_calc (
    .ptr    (cur_ptr),
    .mod    (mod_sel),
    .len    (cur_len),
    .base   (cur_base),
    .circ_en(circ_en_q),
    .mode   (acc_mode),
    .brev_w (brevw_q),
    .addr   (c_addr),
    .new_ptr(c_ptr),
    .upd    (c_upd),
    .wrapped(c_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_addr   <= '0;
      out_ptr    <= '0;
      wrap_pulse <= 1'b0;
    end else begin
      wrap_pulse <= acc_fire && c_wrap;
      if (acc_fire) begin
        out_valid <= 1'b1;
        out_addr  <= c_addr;
        out_ptr   <= c_ptr;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/circ_dag_chk.sv
module circ_dag_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_ready,
  input logic [1:0]    acc_mode,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic [AW-1:0] out_ptr,
  input logic          wrap_pulse,
  input logic [AW-1:0] cur_ptr,
  input logic [AW-1:0] cur_len,
  input logic          circ_en_q
);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_ptr)));

  a_r12_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !acc_ready);

  a_r10_source: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_pulse |-> (out_valid && $past(acc_valid && acc_ready)));

  a_r7_linear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && (!circ_en_q || cur_len == '0)) |=> !wrap_pulse);

  a_r4_pre_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_mode == 2'd1) |=> (out_ptr == $past(cur_ptr) && !wrap_pulse));
endmodule

bind circ_dag circ_dag_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_circ_dag.sv
module test_circ_dag;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 0, ctl_circ_en = 0, ctl_alt_sel = 0;
  logic [5:0]  ctl_brev_w = '0;
  logic        rg_we = 0;
  logic [1:0]  rg_kind = '0;
  logic [2:0]  rg_idx = '0;
  logic [31:0] rg_wdata = '0, rg_rdata;
  logic        acc_valid = 0, acc_ready, acc_use_imm = 0;
  logic [2:0]  acc_idx = '0, acc_mod_idx = '0;
  logic [1:0]  acc_mode = '0;
  logic [31:0] acc_imm = '0;
  logic        out_valid, out_ready = 1'b1, wrap_pulse;
  logic [31:0] out_addr, out_ptr;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mp [2][8];
  logic [31:0] mm [2][8];
  logic [31:0] ml [2][8];
  logic [31:0] mb [2][8];
  bit mcirc = 0;
  int mbank = 0, mw = 0;

  always #2 clk = ~clk;

  circ_dag i_circ_dag (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] brev(logic [31:0] v, int w);
    logic [31:0] r = v;
    int ww = (w > 32) ? 32 : w;
    for (int k = 0; k < ww; k++) r[k] = v[ww-1-k];
    return r;
  endfunction

  function automatic void calc(input logic [31:0] p, m, l, b, input bit c,
                               input logic [1:0] md, input int w,
                               output logic [31:0] a, output logic [31:0] np,
                               output bit wr);
    longint s  = longint'(p) + longint'($signed(m));
    longint bb = longint'(b);
    longint ll = longint'(l);
    wr = 0;
    a  = p;
    np = s[31:0];
    if (md == 2'd1) begin
      a  = s[31:0];
      np = p;
    end else if (md == 2'd2) begin
      a = brev(p, w);
    end else if (c && l != 0) begin
      if (s >= bb + ll) begin np = 32'(s - ll); wr = 1; end
      else if (s < bb) begin np = 32'(s + ll); wr = 1; end
    end
  endfunction

  task automatic wreg(int k, int i, logic [31:0] d);
    @(negedge clk);
    rg_we = 1; rg_kind = 2'(k); rg_idx = 3'(i); rg_wdata = d;
    @(negedge clk);
    rg_we = 0;
    case (k)
      0: mp[mbank][i] = d;
      1: mm[mbank][i] = d;
      2: ml[mbank][i] = d;
      default: mb[mbank][i] = d;
    endcase
  endtask

  task automatic setctl(bit c, bit alt, int w);
    @(negedge clk);
    ctl_we = 1; ctl_circ_en = c; ctl_alt_sel = alt; ctl_brev_w = 6'(w);
    @(negedge clk);
    ctl_we = 0;
    mcirc = c; mbank = alt; mw = w;
  endtask

  task automatic rdchk(string req, int k, int i, logic [31:0] exp);
    @(negedge clk);
    rg_kind = 2'(k); rg_idx = 3'(i);
    #1 chk(req, rg_rdata, exp);
  endtask

  task automatic access(string req, int i, int md, bit imm, int mi, logic [31:0] iv);
    logic [31:0] ea, enp, m;
    bit ew;
    m = imm ? iv : mm[mbank][mi];
    calc(mp[mbank][i], m, ml[mbank][i], mb[mbank][i], mcirc, 2'(md), mw, ea, enp, ew);
    @(negedge clk);
    acc_valid = 1; acc_idx = 3'(i); acc_mode = 2'(md);
    acc_use_imm = imm; acc_mod_idx = 3'(mi); acc_imm = iv;
    @(negedge clk);
    acc_valid = 0;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk({req, " addr"}, out_addr, ea);
    chk({req, " ptr"}, out_ptr, enp);
    chk({req, " wrap"}, 32'(wrap_pulse), 32'(ew));
    if (md != 1) mp[mbank][i] = enp;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2160));
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 8; i++) begin
        mp[b][i] = 0; mm[b][i] = 0; ml[b][i] = 0; mb[b][i] = 0;
      end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 wrap", 32'(wrap_pulse), 0);
    rdchk("R1 len reg", 2, 3, 0);
    rdchk("R1 base reg", 3, 7, 0);
    // R1/R7: length set but circular disabled after reset
    wreg(2, 1, 32'd8); wreg(3, 1, 32'h100); wreg(0, 1, 32'h106); wreg(1, 1, 32'd4);
    rdchk("R2 readback base", 3, 1, 32'h100);
    access("R1 R7 linear post", 1, 0, 0, 1, 0);
    chk("R7 linear ptr", out_ptr, 32'h10A);
    // R6 upward wrap, R10 pulse
    setctl(1, 0, 0);
    wreg(0, 1, 32'h106);
    access("R6 R10 wrap up", 1, 0, 0, 1, 0);
    chk("R6 up value", out_ptr, 32'h102);
    @(negedge clk);
    chk("R10 pulse one cycle", 32'(wrap_pulse), 0);
    // R5 R6 signed immediate, downward wrap
    wreg(0, 1, 32'h101);
    access("R5 R6 wrap down", 1, 0, 1, 0, 32'hFFFF_FFFD);
    chk("R6 down value", out_ptr, 32'h106);
    // R4 pre-modify
    access("R4 pre", 1, 1, 0, 1, 0);
    rdchk("R4 ptr unchanged", 0, 1, 32'h106);
    // R7 zero length with circular on
    wreg(0, 4, 32'hFFFF_FFFE); wreg(1, 4, 32'd5);
    access("R7 len zero", 4, 0, 0, 4, 0);
    chk("R3 modulo 2^32", out_ptr, 32'h3);
    // R8 bit reverse, no wrap even with a circular window
    setctl(1, 0, 4);
    wreg(0, 6, 32'h1003); wreg(2, 6, 32'd2); wreg(3, 6, 32'h1000);
    access("R8 brev", 6, 2, 1, 0, 32'd1);
    chk("R8 brev addr", out_addr, 32'h100C);
    chk("R8 no wrap", out_ptr, 32'h1004);
    access("R12 mode3 as post", 1, 3, 1, 0, 32'd1);
    // R9 alternate bank
    setctl(1, 1, 4);
    rdchk("R9 alt starts clear", 0, 1, 0);
    wreg(0, 1, 32'h55);
    rdchk("R9 alt write", 0, 1, 32'h55);
    setctl(1, 0, 4);
    rdchk("R9 primary kept", 0, 1, mp[0][1]);
    // R11 same-cycle write priority
    wreg(0, 2, 32'h40); wreg(1, 2, 32'd8);
    @(negedge clk);
    rg_we = 1; rg_kind = 2'd0; rg_idx = 3'd2; rg_wdata = 32'h777;
    acc_valid = 1; acc_idx = 3'd2; acc_mode = 2'd0; acc_use_imm = 0; acc_mod_idx = 3'd2;
    @(negedge clk);
    rg_we = 0; acc_valid = 0;
    chk("R11 addr uses old ptr", out_addr, 32'h40);
    mp[0][2] = 32'h777;
    rdchk("R11 write wins", 0, 2, 32'h777);
    // R12 back-pressure
    wreg(0, 5, 32'h20); wreg(1, 5, 32'd2);
    @(negedge clk);
    out_ready = 0;
    acc_valid = 1; acc_idx = 3'd5; acc_mode = 2'd0; acc_use_imm = 0; acc_mod_idx = 3'd5;
    @(negedge clk);
    chk("R12 first valid", 32'(out_valid), 1);
    chk("R12 first addr", out_addr, 32'h20);
    @(negedge clk);
    chk("R12 held addr", out_addr, 32'h20);
    chk("R12 held ptr", out_ptr, 32'h22);
    chk("R12 not ready", 32'(acc_ready), 0);
    out_ready = 1;
    @(negedge clk);
    acc_valid = 0;
    chk("R12 second addr", out_addr, 32'h22);
    mp[0][5] = 32'h24;
    rdchk("R12 single accept", 0, 5, 32'h24);
    // random mix
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 9);
      int i = $urandom_range(0, 7);
      if (op == 0) begin
        setctl(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), $urandom_range(0, 33));
      end else if (op <= 3) begin
        logic [31:0] b = 32'h1000 + 32'($urandom_range(0, 255));
        logic [31:0] l = 32'($urandom_range(0, 16));
        wreg(3, i, b); wreg(2, i, l);
        wreg(0, i, b + 32'($urandom_range(0, 16)));
        wreg(1, i, 32'($signed($urandom_range(0, 40)) - 20));
      end else if (op == 4) begin
        rdchk("R2 random readback", 0, i, mp[mbank][i]);
      end else begin
        int md = $urandom_range(0, 3);
        bit im = bit'($urandom_range(0, 1));
        logic [31:0] iv = 32'($signed($urandom_range(0, 32)) - 16);
        access(md == 1 ? "R4 random" : (md == 2 ? "R8 random" : "R3 R6 random"),
               i, md, im, $urandom_range(0, 7), iv);
      end
    end
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule